// File: doc/BRIEF.md
# Range-Finder Integration Sequence Controller

This block sequences a ratio-measuring double-integration range sensor. A host drives two lines, a hold line and an integrate line, and the block decodes them into the enables the analog side needs: fast precharge of the integrating capacitor, fast precharge of the ambient-hold capacitor, ambient-light hold, the first (up) integration and the second (down) integration. It also drives an active-low measurement pulse. The width of that pulse is the distance result that the host times.

The second integration runs while the integrate line is high and the hold line is low. It ends early when a digital threshold-crossed input asserts. That input stands in for the analog comparator. A status flag tells the host whether the last down phase ended on the threshold or on the integrate line falling.

The internal reset is the OR of a power-on reset and a reset pin. The block leaves reset when the reset pin falls. A standby pin forces every output to idle and freezes the sequence. All control pins pass through two-flop synchronizers before any edge is taken from them.

Top module: `range_seq_top`

## Requirements
- R1: While porIn or resetPin is high, integCapCharge, holdCapCharge, ambientHold, integUp, integDown and tripFlag are low, and soutN is high.
- R2: After reset release, integCapCharge is high until the first falling edge of intPin. It then stays low until the next reset.
- R3: After reset release, holdCapCharge stays high until intPin has risen and then fallen. If intPin is already high when reset releases, that level does not count as a rise.
- R4: ambientHold follows holdPin while the block is out of reset and standby.
- R5: integUp is high exactly when holdPin and intPin are both high.
- R6: integDown goes high when intPin is high with holdPin low, and soutN goes low at the same time.
- R7: When tripPin asserts during a down integration, integDown falls and soutN returns high while intPin is still high. tripFlag then reads 1.
- R8: When intPin falls during a down integration with no trip, integDown ends and soutN returns high with tripFlag reading 0.
- R9: After a trip, the down integration does not restart, even if tripPin drops, until intPin goes low and then high again with holdPin low. A new down integration clears tripFlag.
- R10: While stbyPin is high, all enables and tripFlag are low and soutN is high. Edges of intPin seen during standby do not advance the precharge state.
- R11: Each output reacts in the third rising clock edge after its input pin changes: two synchronizer stages and one output register.
- R12: A new reset pulse on resetPin mid-sequence restores both precharge outputs to high after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| porIn | input | 1 | Power-on reset, active high, asynchronous |
| resetPin | input | 1 | External reset, active high; release on its fall |
| stbyPin | input | 1 | Standby request, active high |
| holdPin | input | 1 | Host hold line |
| intPin | input | 1 | Host integrate line |
| tripPin | input | 1 | Threshold-crossed indication |
| integCapCharge | output | 1 | Integrating capacitor rapid precharge |
| holdCapCharge | output | 1 | Hold capacitor rapid precharge |
| ambientHold | output | 1 | Ambient-light hold enable |
| integUp | output | 1 | First integration enable |
| integDown | output | 1 | Second integration enable |
| soutN | output | 1 | Measurement pulse, active low, idles high |
| tripFlag | output | 1 | Last down phase was ended by the threshold |

## Verification
The bench aims at the difference between the two precharge endings. It releases reset with intPin already high. A design that treated that level as a rise would drop holdCapCharge on the first fall instead of the second. The bench holds tripPin high and then drops it while intPin stays high. A design without the trip lockout would restart the down integration and pull soutN low a second time. It toggles intPin during standby, which a design that kept sequencing would show as a lost precharge after standby ends. It also samples the exact edge at which the pipeline latency puts a hold change onto the outputs.

// File: rtl/range_seq_pkg.sv
package range_seq_pkg;
  typedef struct packed {
    logic cintChg;
    logic holdChg;
    logic ambHold;
    logic upInt;
    logic downInt;
    logic tripFlag;
  } seq_strobe_t;

  localparam seq_strobe_t STROBE_IDLE = '{default: 1'b0};
endpackage

// File: rtl/range_seq_sync.sv
module range_seq_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             por,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or posedge por) begin
          if (por) chain[s] <= '0;
          else     chain[s] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or posedge por) begin
          if (por) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/range_seq_ctrl.sv
module range_seq_ctrl
  import range_seq_pkg::*;
(
  input  logic        clk,
  input  logic        por,
  input  logic        rstSync,
  input  logic        stbySync,
  input  logic        holdSync,
  input  logic        intSync,
  input  logic        tripSync,
  output seq_strobe_t strb
);
  logic intPrev, cintDone, holdRose, holdDone, tripLock, tripSeen;
  logic intRise, intFall, downCond, tripEvt;

  always_comb begin
    intRise  = !intPrev && intSync;
    intFall  = intPrev && !intSync;
    downCond = !holdSync && intSync && !tripLock;
    tripEvt  = downCond && tripSync;
    strb.cintChg  = !(cintDone || intFall);
    strb.holdChg  = !(holdDone || (holdRose && intFall));
    strb.ambHold  = holdSync;
    strb.upInt    = holdSync && intSync;
    strb.downInt  = downCond && !tripSync;
    strb.tripFlag = strb.downInt ? 1'b0 : (tripSeen || tripEvt);
  end

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      intPrev  <= 1'b0;
      cintDone <= 1'b0;
      holdRose <= 1'b0;
      holdDone <= 1'b0;
      tripLock <= 1'b0;
      tripSeen <= 1'b0;
    end else if (rstSync) begin
      intPrev  <= intSync;
      cintDone <= 1'b0;
      holdRose <= 1'b0;
      holdDone <= 1'b0;
      tripLock <= 1'b0;
      tripSeen <= 1'b0;
    end else if (stbySync) begin
      intPrev  <= intSync;
    end else begin
      intPrev  <= intSync;
      cintDone <= cintDone || intFall;
      holdRose <= holdRose || intRise;
      holdDone <= holdDone || (holdRose && intFall);
      if (!intSync)     tripLock <= 1'b0;
      else if (tripEvt) tripLock <= 1'b1;
      tripSeen <= strb.tripFlag;
    end
  end

  // R2: once the first fall is recorded, the precharge request stays off
  assert_cint_sticky_R2: assert property (@(posedge clk) disable iff (por || rstSync)
    $past(cintDone) |-> !strb.cintChg);

  // R9: a trip lockout with INT still high keeps the down phase off next cycle
  assert_lock_hold_R9: assert property (@(posedge clk) disable iff (por || rstSync)
    (tripLock && intSync) |=> !strb.downInt);
endmodule

// File: rtl/range_seq_dp.sv
module range_seq_dp
  import range_seq_pkg::*;
(
  input  logic        clk,
  input  logic        por,
  input  logic        rstSync,
  input  logic        stbySync,
  input  seq_strobe_t strb,
  output logic        integCapCharge,
  output logic        holdCapCharge,
  output logic        ambientHold,
  output logic        integUp,
  output logic        integDown,
  output logic        soutN,
  output logic        tripFlag
);
  seq_strobe_t gated;

  always_comb gated = stbySync ? STROBE_IDLE : strb;

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      integCapCharge <= 1'b0;
      holdCapCharge  <= 1'b0;
      ambientHold    <= 1'b0;
      integUp        <= 1'b0;
      integDown      <= 1'b0;
      soutN          <= 1'b1;
      tripFlag       <= 1'b0;
    end else if (rstSync) begin
      integCapCharge <= 1'b0;
      holdCapCharge  <= 1'b0;
      ambientHold    <= 1'b0;
      integUp        <= 1'b0;
      integDown      <= 1'b0;
      soutN          <= 1'b1;
      tripFlag       <= 1'b0;
    end else begin
      integCapCharge <= gated.cintChg;
      holdCapCharge  <= gated.holdChg;
      ambientHold    <= gated.ambHold;
      integUp        <= gated.upInt;
      integDown      <= gated.downInt;
      soutN          <= !gated.downInt;
      tripFlag       <= gated.tripFlag;
    end
  end

  // R10: standby seen at an edge leaves everything idle after it
  assert_standby_idle_R10: assert property (@(posedge clk) disable iff (por || rstSync)
    $past(stbySync) |-> (!integCapCharge && !holdCapCharge && !ambientHold &&
                         !integUp && !integDown && soutN && !tripFlag));

  // R3: the hold-capacitor precharge never ends before the integrator precharge
  assert_precharge_order_R3: assert property (@(posedge clk) disable iff (por || rstSync)
    integCapCharge |-> holdCapCharge);

  // R5: up and down integration are never enabled together
  assert_phase_excl_R5: assert property (@(posedge clk) disable iff (por || rstSync)
    !(integUp && integDown));

  // R6: the measurement pulse starts together with the down phase
  assert_sout_start_R6: assert property (@(posedge clk) disable iff (por || rstSync)
    $rose(integDown) |-> $fell(soutN));
endmodule

// File: rtl/range_seq_top.sv
module range_seq_top
  import range_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic porIn,
  input  logic resetPin,
  input  logic stbyPin,
  input  logic holdPin,
  input  logic intPin,
  input  logic tripPin,
  output logic integCapCharge,
  output logic holdCapCharge,
  output logic ambientHold,
  output logic integUp,
  output logic integDown,
  output logic soutN,
  output logic tripFlag
);
  localparam int NUM_PINS = 5;

  logic [NUM_PINS-1:0] pinRaw, pinSync;
  seq_strobe_t         strb;

  assign pinRaw = {resetPin, stbyPin, holdPin, intPin, tripPin};

  range_seq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .por(porIn), .asyncIn(pinRaw), .syncOut(pinSync)
  );

  range_seq_ctrl u_ctrl (
    .clk(clk), .por(porIn),
    .rstSync(pinSync[4]), .stbySync(pinSync[3]),
    .holdSync(pinSync[2]), .intSync(pinSync[1]), .tripSync(pinSync[0]),
    .strb(strb)
  );

  range_seq_dp u_dp (
    .clk(clk), .por(porIn),
    .rstSync(pinSync[4]), .stbySync(pinSync[3]), .strb(strb),
    .integCapCharge(integCapCharge), .holdCapCharge(holdCapCharge),
    .ambientHold(ambientHold), .integUp(integUp), .integDown(integDown),
    .soutN(soutN), .tripFlag(tripFlag)
  );
endmodule

// File: tb/tb_range_seq_top.sv
module tb_range_seq_top;
  logic clk = 1'b0;
  logic porIn = 1'b1, resetPin = 1'b1, stbyPin = 1'b0;
  logic holdPin = 1'b0, intPin = 1'b0, tripPin = 1'b0;
  logic integCapCharge, holdCapCharge, ambientHold, integUp, integDown, soutN, tripFlag;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  range_seq_top dut (
    .clk(clk), .porIn(porIn), .resetPin(resetPin), .stbyPin(stbyPin),
    .holdPin(holdPin), .intPin(intPin), .tripPin(tripPin),
    .integCapCharge(integCapCharge), .holdCapCharge(holdCapCharge),
    .ambientHold(ambientHold), .integUp(integUp), .integDown(integDown),
    .soutN(soutN), .tripFlag(tripFlag)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drive(logic h, logic i, logic t);
    @(negedge clk);
    holdPin = h; intPin = i; tripPin = t;
    tick(4);
  endtask

  task automatic check_idle(string req);
    chk(req, "integCapCharge", integCapCharge, 1'b0);
    chk(req, "holdCapCharge", holdCapCharge, 1'b0);
    chk(req, "ambientHold", ambientHold, 1'b0);
    chk(req, "integUp", integUp, 1'b0);
    chk(req, "integDown", integDown, 1'b0);
    chk(req, "soutN", soutN, 1'b1);
    chk(req, "tripFlag", tripFlag, 1'b0);
  endtask

  task automatic do_reset(logic intAtRelease);
    @(negedge clk);
    resetPin = 1'b1; holdPin = 1'b0; intPin = intAtRelease; tripPin = 1'b0;
    tick(4);
    @(negedge clk);
    resetPin = 1'b0;
    tick(4);
  endtask

  task automatic test_reset_R1;
    tick(2);
    check_idle("R1");
    @(negedge clk); porIn = 1'b0; holdPin = 1'b1; intPin = 1'b1;
    tick(4);
    check_idle("R1");
    do_reset(1'b0);
    chk("R2", "cint charge after release", integCapCharge, 1'b1);
    chk("R3", "hold charge after release", holdCapCharge, 1'b1);
    chk("R1", "soutN after release", soutN, 1'b1);
  endtask

  task automatic test_latency_R11;
    @(negedge clk); holdPin = 1'b1;
    tick(2);
    chk("R11", "ambientHold before third edge", ambientHold, 1'b0);
    tick(1);
    chk("R11", "ambientHold at third edge", ambientHold, 1'b1);
    chk("R4", "ambientHold follows hold", ambientHold, 1'b1);
  endtask

  task automatic test_first_phase;
    drive(1'b1, 1'b1, 1'b0);
    chk("R5", "integUp with hold and int high", integUp, 1'b1);
    chk("R2", "cint charge while int high", integCapCharge, 1'b1);
    drive(1'b1, 1'b0, 1'b0);
    chk("R5", "integUp after int fall", integUp, 1'b0);
    chk("R2", "cint charge after first fall", integCapCharge, 1'b0);
    chk("R3", "hold charge after rise and fall", holdCapCharge, 1'b0);
    drive(1'b0, 1'b0, 1'b0);
    chk("R4", "ambientHold after hold low", ambientHold, 1'b0);
  endtask

  task automatic test_high_release_R3;
    do_reset(1'b1);
    drive(1'b0, 1'b0, 1'b0);
    chk("R2", "cint ends on first fall", integCapCharge, 1'b0);
    chk("R3", "hold charge kept, no rise seen", holdCapCharge, 1'b1);
    drive(1'b1, 1'b1, 1'b0);
    drive(1'b1, 1'b0, 1'b0);
    chk("R3", "hold charge ends after rise/fall", holdCapCharge, 1'b0);
    drive(1'b0, 1'b0, 1'b0);
  endtask

  task automatic test_trip;
    drive(1'b0, 1'b1, 1'b0);
    chk("R6", "integDown starts", integDown, 1'b1);
    chk("R6", "soutN low", soutN, 1'b0);
    chk("R5", "integUp off with hold low", integUp, 1'b0);
    drive(1'b0, 1'b1, 1'b1);
    chk("R7", "integDown ended by trip", integDown, 1'b0);
    chk("R7", "soutN high after trip", soutN, 1'b1);
    chk("R7", "tripFlag set", tripFlag, 1'b1);
    drive(1'b0, 1'b1, 1'b0);
    chk("R9", "no restart after trip drops", integDown, 1'b0);
    chk("R9", "soutN stays high", soutN, 1'b1);
    drive(1'b0, 1'b0, 1'b0);
    drive(1'b0, 1'b1, 1'b0);
    chk("R9", "restart after int low/high", integDown, 1'b1);
    chk("R9", "tripFlag cleared by new down", tripFlag, 1'b0);
    drive(1'b0, 1'b0, 1'b0);
    chk("R8", "integDown ends on int fall", integDown, 1'b0);
    chk("R8", "soutN high on int fall", soutN, 1'b1);
    chk("R8", "tripFlag low on timeout", tripFlag, 1'b0);
  endtask

  task automatic test_standby_R10;
    do_reset(1'b0);
    @(negedge clk); stbyPin = 1'b1;
    drive(1'b1, 1'b1, 1'b0);
    check_idle("R10");
    drive(1'b1, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b0);
    @(negedge clk); stbyPin = 1'b0;
    tick(4);
    chk("R10", "cint charge kept over standby", integCapCharge, 1'b1);
    chk("R10", "hold charge kept over standby", holdCapCharge, 1'b1);
  endtask

  task automatic test_rereset_R12;
    drive(1'b1, 1'b1, 1'b0);
    drive(1'b1, 1'b0, 1'b0);
    chk("R12", "cint charge off before re-reset", integCapCharge, 1'b0);
    do_reset(1'b0);
    chk("R12", "cint charge restored", integCapCharge, 1'b1);
    chk("R12", "hold charge restored", holdCapCharge, 1'b1);
  endtask

  initial begin
    test_reset_R1();
    test_latency_R11();
    test_first_phase();
    test_trip();
    test_high_release_R3();
    test_standby_R10();
    test_rereset_R12();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule